// File: doc/BRIEF.md
# Power Mode Control Register

This block is the byte-wide power and mode control register of a small microcontroller core. Software writes it to request the idle or power-down sleep states, to arm a one-shot permission for reloading the watchdog timer, to double the serial baud rate, and to keep two scratch flags. The CPU reads the register back at any time. The stored sleep requests drive the clock-gating logic outside the block. They stay asserted until a wake pulse from the interrupt logic or a reset clears them.

The watchdog timer presents each reload attempt as a one-cycle pulse. The block grants the attempt only when software has armed the load-enable flag. Each grant consumes the flag. Power-down is accepted only while an external enable pin is high. When one write asks for both sleep states, power-down wins. The baud-doubling output is qualified with the current serial mode, because the doubling applies only outside the synchronous shift mode.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 8'h60, and `idle_o`, `pdown_o`, `wdt_load_ok` and `baud_x2` are all 0.
- R2: The read layout is as follows: bit 7 is the baud-double bit, bits 6:5 always read 1, bit 4 is the load-enable flag, bits 3:2 are the scratch flags, bit 1 is power-down and bit 0 is idle. Writes to bits 6:5 have no effect on the read value.
- R3: On a write, bits 7, 3 and 2 take the written values in the next cycle. Bit 4 also takes its written value, unless R8 applies.
- R4: Power-down becomes 1 in the cycle after a write with bit 1 set, but only if `pd_allow` is high in the write cycle. If `pd_allow` is low, power-down is unchanged.
- R5: Idle becomes 1 after a write with bit 0 set. This does not happen if the same write sets power-down (power-down takes precedence), or if power-down is already 1.
- R6: A write of 0 to bits 1 or 0 does not clear a set power-down or idle bit. Both stay held until a wake pulse or a reset.
- R7: A `wake_pulse` clears both power-down and idle in the next cycle. It overrides a write in the same cycle that would set either bit.
- R8: A `wdt_reload_req` while the load-enable flag is 1 raises `wdt_load_ok` for one cycle in the next cycle and clears the flag. The clear overrides a same-cycle write of bit 4.
- R9: A `wdt_reload_req` while the load-enable flag is 0 is rejected: `wdt_load_ok` stays 0.
- R10: `baud_x2` equals the stored baud-double bit ANDed with (`sio_mode` != 0), one cycle later. Serial mode 0 never sees doubling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| pd_allow | input | 1 | External enable for power-down |
| wake_pulse | input | 1 | Clears both sleep requests |
| sio_mode | input | SMODE_W | Current serial port mode |
| wdt_reload_req | input | 1 | Watchdog reload attempt pulse |
| wdt_load_ok | output | 1 | Reload granted, one-cycle pulse |
| idle_o | output | 1 | Idle request held |
| pdown_o | output | 1 | Power-down request held |
| baud_x2 | output | 1 | Baud doubling in effect |

## Verification
The bench builds the block with its defaults: an 8-bit register and a 2-bit serial mode. This keeps all 256 write values, both levels of the power-down enable and all four serial modes within one sweep. Each value is applied from a cleared state and again with sleep bits already set. Reload attempts run with the flag set and with it clear. Wake pulses and reloads are also made to coincide with writes, which covers every priority case.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W  = 8;
  localparam int B_BAUD  = 7;
  localparam int B_RSV_H = 6;
  localparam int B_RSV_L = 5;
  localparam int B_WLD   = 4;
  localparam int B_GP_H  = 3;
  localparam int B_GP_L  = 2;
  localparam int B_PDN   = 1;
  localparam int B_IDL   = 0;
  localparam int GP_N    = B_GP_H - B_GP_L + 1;
  localparam int RSV_N   = B_RSV_H - B_RSV_L + 1;
endpackage

// File: rtl/pmc_sleep_ctl.sv
module pmc_sleep_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_pdn,
  input  logic wr_idl,
  input  logic pd_allow,
  input  logic wake_pulse,
  output logic pdown_q,
  output logic idle_q
);
  logic pd_take;
  logic idl_take;

  always_comb begin
    pd_take  = wr_en && wr_pdn && pd_allow;
    idl_take = wr_en && wr_idl && !pd_take && !pdown_q;
  end

  always_ff @(posedge clk) begin
    if (rst || wake_pulse) begin
      pdown_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      if (pd_take)  pdown_q <= 1'b1;
      if (idl_take) idle_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/pmc_reload_gate.sv
module pmc_reload_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_wld,
  input  logic reload_req,
  output logic wld_q,
  output logic load_ok
);
  logic grant;

  assign grant = reload_req && wld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wld_q   <= 1'b0;
      load_ok <= 1'b0;
    end else begin
      load_ok <= grant;
      if (grant)      wld_q <= 1'b0;
      else if (wr_en) wld_q <= wr_wld;
    end
  end
endmodule

// File: rtl/pmc_baud_sel.sv
module pmc_baud_sel #(
  parameter int SMODE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_baud,
  input  logic [SMODE_W-1:0] sio_mode,
  output logic               baud_q,
  output logic               baud_x2
);
  localparam logic [SMODE_W-1:0] SHIFT_MODE = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q  <= 1'b0;
      baud_x2 <= 1'b0;
    end else begin
      baud_x2 <= baud_q && (sio_mode != SHIFT_MODE);
      if (wr_en) baud_q <= wr_baud;
    end
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int SMODE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               pd_allow,
  input  logic               wake_pulse,
  input  logic [SMODE_W-1:0] sio_mode,
  input  logic               wdt_reload_req,
  output logic               wdt_load_ok,
  output logic               idle_o,
  output logic               pdown_o,
  output logic               baud_x2
);
  logic            baud_q;
  logic            wld_q;
  logic [GP_N-1:0] gp_q;

  pmc_sleep_ctl u_sleep (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_pdn     (wr_data[B_PDN]),
    .wr_idl     (wr_data[B_IDL]),
    .pd_allow   (pd_allow),
    .wake_pulse (wake_pulse),
    .pdown_q    (pdown_o),
    .idle_q     (idle_o)
  );

  pmc_reload_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_wld     (wr_data[B_WLD]),
    .reload_req (wdt_reload_req),
    .wld_q      (wld_q),
    .load_ok    (wdt_load_ok)
  );

  pmc_baud_sel #(.SMODE_W(SMODE_W)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_baud  (wr_data[B_BAUD]),
    .sio_mode (sio_mode),
    .baud_q   (baud_q),
    .baud_x2  (baud_x2)
  );

  for (genvar g = 0; g < GP_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        gp_q[g] <= 1'b0;
      else if (wr_en) gp_q[g] <= wr_data[B_GP_L+g];
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[B_BAUD]          = baud_q;
    rd_data[B_RSV_H:B_RSV_L] = {RSV_N{1'b1}};
    rd_data[B_WLD]           = wld_q;
    rd_data[B_GP_H:B_GP_L]   = gp_q;
    rd_data[B_PDN]           = pdown_o;
    rd_data[B_IDL]           = idle_o;
  end
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk #(
  parameter int SMODE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [7:0]         wr_data,
  input logic [7:0]         rd_data,
  input logic               pd_allow,
  input logic               wake_pulse,
  input logic [SMODE_W-1:0] sio_mode,
  input logic               wdt_reload_req,
  input logic               wdt_load_ok,
  input logic               idle_o,
  input logic               pdown_o,
  input logic               baud_x2
);
  // R4
  pdown_needs_allow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pdown_o) |-> ($past(pd_allow) && $past(wr_en)));
  // R5
  pdown_beats_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pdown_o) |-> !$rose(idle_o));
  // R6
  idle_held_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_o && !wake_pulse) |=> idle_o);
  // R7
  wake_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> (!idle_o && !pdown_o));
  // R8
  reload_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_reload_req && rd_data[4]) |=> (wdt_load_ok && !rd_data[4]));
  // R9
  reload_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_reload_req && !rd_data[4]) |=> !wdt_load_ok);
  // R10
  baud_on_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && (sio_mode != '0)) |=> baud_x2);
  // R10
  baud_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_data[7] && (sio_mode != '0)) |=> !baud_x2);
endmodule

bind pmc_ctrl pmc_ctrl_chk #(.SMODE_W(SMODE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .pd_allow       (pd_allow),
  .wake_pulse     (wake_pulse),
  .sio_mode       (sio_mode),
  .wdt_reload_req (wdt_reload_req),
  .wdt_load_ok    (wdt_load_ok),
  .idle_o         (idle_o),
  .pdown_o        (pdown_o),
  .baud_x2        (baud_x2)
);

// File: tb/test_pmc_ctrl.sv
`timescale 1ns/1ps
module test_pmc_ctrl;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       pd_allow = 0;
  logic       wake_pulse = 0;
  logic [1:0] sio_mode = 0;
  logic       wdt_reload_req = 0;
  logic       wdt_load_ok, idle_o, pdown_o, baud_x2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic m_baud, m_wl, m_pd, m_id, m_ok, m_bx;
  logic [1:0] m_gp;

  always #4 clk = ~clk;

  pmc_ctrl i_pmc_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pd_allow(pd_allow), .wake_pulse(wake_pulse), .sio_mode(sio_mode),
    .wdt_reload_req(wdt_reload_req), .wdt_load_ok(wdt_load_ok),
    .idle_o(idle_o), .pdown_o(pdown_o), .baud_x2(baud_x2));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_baud = 0; m_wl = 0; m_pd = 0; m_id = 0; m_ok = 0; m_bx = 0; m_gp = 0;
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit wr, input logic [7:0] d, input bit allow,
                      input bit wk, input bit rel, input logic [1:0] mode);
    logic pd_take, grant;
    wr_en = wr; wr_data = d; pd_allow = allow; wake_pulse = wk;
    wdt_reload_req = rel; sio_mode = mode;
    pd_take = wr && d[1] && allow;
    grant   = rel && m_wl;
    m_bx = m_baud && (mode != 0);
    m_ok = grant;
    if (grant) m_wl = 0; else if (wr) m_wl = d[4];
    if (wk) begin m_pd = 0; m_id = 0; end
    else begin
      if (wr && d[0] && !pd_take && !m_pd) m_id = 1;
      if (pd_take) m_pd = 1;
    end
    if (wr) begin m_baud = d[7]; m_gp = d[3:2]; end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wake_pulse = 0; wdt_reload_req = 0;
    chk({7'b0, rd_data[7]}, {7'b0, m_baud}, "R3 baud bit");
    chk({6'b0, rd_data[6:5]}, 8'h03, "R2 reserved");
    chk({6'b0, rd_data[3:2]}, {6'b0, m_gp}, "R3 flags");
    chk({7'b0, rd_data[4]}, {7'b0, m_wl}, "R8 load flag");
    chk({7'b0, pdown_o}, {7'b0, m_pd}, "R4 pdown");
    chk({7'b0, idle_o}, {7'b0, m_id}, "R5 idle");
    chk({6'b0, rd_data[1:0]}, {6'b0, m_pd, m_id}, "R6 read of mode bits");
    chk({7'b0, wdt_load_ok}, {7'b0, m_ok}, grant ? "R8 grant" : "R9 no grant");
    chk({7'b0, baud_x2}, {7'b0, m_bx}, "R10 baud_x2");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rd_data, 8'h60, "R1 rd_data");
    chk({4'b0, idle_o, pdown_o, wdt_load_ok, baud_x2}, 8'h00, "R1 outputs");

    // sweep from cleared sleep state: every value, enable level and mode
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 2; a++)
        for (int d = 0; d < 256; d++) begin
          step(0, 8'h00, 0, 1, 0, m[1:0]);                    // R7 clear
          step(1, d[7:0], a[0], 0, 0, m[1:0]);                 // R2..R5
          step(0, 8'h00, 0, 0, d[4] ^ d[6], m[1:0]);           // R8/R9
          step(1, 8'h00, a[0], 0, 0, m[1:0]);                  // R6 zeros
        end

    // sweep with sleep bits already set
    for (int d = 0; d < 256; d++) begin
      step(0, 8'h00, 0, 1, 0, 2'd1);
      step(1, 8'h01, 0, 0, 0, 2'd1);                           // idle set
      step(1, d[7:0], 1, 0, 0, 2'd1);
      step(1, 8'h02, 1, 0, 0, 2'd2);                           // pdown set
      step(1, d[7:0], 1, 0, 0, 2'd3);                          // R5 blocked idle
    end

    // R7 wake beats a same-cycle write
    step(0, 8'h00, 0, 1, 0, 2'd0);
    step(1, 8'h03, 1, 1, 0, 2'd0);
    step(1, 8'h01, 0, 1, 0, 2'd0);
    // R8 grant beats a same-cycle write of the flag
    step(1, 8'h10, 0, 0, 0, 2'd0);
    step(1, 8'h10, 0, 0, 1, 2'd0);
    step(0, 8'h00, 0, 0, 1, 2'd0);                             // R9 flag now 0
    // R9 repeated rejections
    for (int k = 0; k < 4; k++) step(0, 8'h00, 0, 0, 1, k[1:0]);

    // R1 reset again from a busy state
    step(1, 8'hFE, 1, 0, 0, 2'd3);
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    chk(rd_data, 8'h60, "R1 rd_data after second reset");
    chk({4'b0, idle_o, pdown_o, wdt_load_ok, baud_x2}, 8'h00, "R1 outputs after second reset");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule